// File: doc/BRIEF.md
# Jump-Table Vector Register Access Gate

This block guards the register that holds the base address and mode of a jump table used by table-jump instructions. On every access to that register it decides whether the access may proceed. If it may not, the block says which trap the core must raise: an illegal-instruction trap or a virtual-instruction trap. The block also holds the register itself, returns its contents for reads, and loads it on permitted writes.

The decision has three stages. The generic privilege check for register access is computed elsewhere and arrives as one input. If that check fails, its result stands and this block adds nothing. If it passes, the block may apply three state-enable gates, taken from the machine, hypervisor and supervisor state-enable 0 registers. These gates apply only when state-enable support is configured. They are tried in a fixed order, and the first gate that fails decides the trap. A failed supervisor gate yields a virtual-instruction trap while the hart runs virtualized, and an illegal-instruction trap otherwise.

Decoding of register addresses in general and the delivery of traps are handled outside this block.

Top module: `jtab_csr_gate`

## Requirements
- R1: When `base_ok` is low during a valid access, `allow`, `trap_illegal` and `trap_virtual` are all low, and the register is not written.
- R2: When `stateen_on` is low and `base_ok` is high during a valid access, `allow` is high whatever the state-enable values, privilege or virtualization flag.
- R3: With gating active, a privilege below machine (`prv` not 3, encoded user = 0, supervisor = 1, machine = 3) and bit 2 of `m_se` clear raise `trap_illegal`.
- R4: With gating active and the machine gate passed, `virt_on` high and bit 2 of `h_se` clear raise `trap_virtual`.
- R5: With gating active and the machine and hypervisor gates passed, `super_on` high, `prv` = 0 and bit 2 of `s_se` clear raise `trap_virtual` if `virt_on` is high and `trap_illegal` if it is low.
- R6: The gates are evaluated in the order machine, hypervisor, supervisor, and the first one that fails alone sets the trap kind. Only bit 2 of each state-enable value affects the result.
- R7: At most one of `trap_illegal`, `trap_virtual` and `allow` is high. All three are low when `acc_valid` is low.
- R8: `rd_data` is zero after reset and always shows the stored register value.
- R9: The register takes `acc_wdata` on the clock edge where `acc_valid`, `acc_write` and `allow` are all high, and it holds its value on every other edge.
- R10: When the table-jump feature parameter is 0, bit 2 of every state-enable input reads as zero. Any gated access below machine level then traps as illegal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | An access to the jump-table register is presented this cycle |
| acc_write | input | 1 | The access is a write |
| acc_wdata | input | XLEN | Write data |
| base_ok | input | 1 | Result of the generic register privilege check (1 = pass) |
| stateen_on | input | 1 | State-enable support is configured |
| super_on | input | 1 | Supervisor mode exists |
| virt_on | input | 1 | The hart is in virtualization mode |
| prv | input | 2 | Current privilege: 0 user, 1 supervisor, 3 machine |
| m_se | input | SE_W | Machine state-enable 0 value |
| h_se | input | SE_W | Hypervisor state-enable 0 value |
| s_se | input | SE_W | Supervisor state-enable 0 value |
| allow | output | 1 | Access permitted |
| trap_illegal | output | 1 | Raise an illegal-instruction trap |
| trap_virtual | output | 1 | Raise a virtual-instruction trap |
| rd_data | output | XLEN | Current register contents |

## Verification
Two things can happen in the same cycle: the permission decision and the register update, because a write is presented together with its gate inputs. Each of the 512 combinations of privilege, virtualization flag, the three enable bits, the two configuration flags and the generic check result is driven with a fresh write value. The bench judges the trap outputs from an arithmetic model. On the following cycle it checks whether the register took the value or kept the old one. The same sweep runs on a second instance built without the table-jump feature, where every gated access below machine level must be refused and must leave the register untouched.

// File: rtl/jtg_pkg.sv
`timescale 1ns/1ps
package jtg_pkg;
   typedef enum logic [1:0] {
      LVL_USER  = 2'd0,
      LVL_SUPER = 2'd1,
      LVL_RSVD  = 2'd2,
      LVL_MACH  = 2'd3
   } lvl_e;

   localparam int unsigned DEF_XLEN   = 32;
   localparam int unsigned DEF_SE_W   = 64;
   localparam int unsigned DEF_JT_BIT = 2;
endpackage

// File: rtl/jtg_enable_tap.sv
`timescale 1ns/1ps
module jtg_enable_tap #(
   parameter int unsigned SE_W    = 64,
   parameter int unsigned BIT_POS = 2,
   parameter bit          PRESENT = 1'b1
) (
   input  logic [SE_W-1:0] se,
   output logic            en
);
   if (BIT_POS >= SE_W) begin : g_bad_pos
      $error("jtg_enable_tap: BIT_POS outside the state-enable word");
   end

   if (PRESENT) begin : g_live
      logic unused_se;
      assign unused_se = ^se;
      assign en = se[BIT_POS];
   end else begin : g_tied
      logic unused_se;
      assign unused_se = ^se;
      assign en = 1'b0;
   end
endmodule

// File: rtl/jtg_gate_eval.sv
`timescale 1ns/1ps
module jtg_gate_eval
   import jtg_pkg::*;
(
   input  logic valid,
   input  logic base_ok,
   input  logic stateen_on,
   input  logic super_on,
   input  logic virt_on,
   input  lvl_e lvl,
   input  logic m_en,
   input  logic h_en,
   input  logic s_en,
   output logic allow,
   output logic trap_ill,
   output logic trap_vrt
);
   logic gated;
   logic m_fail;
   logic h_fail;
   logic s_fail;

   always_comb begin
      gated  = valid && base_ok && stateen_on;
      m_fail = (lvl != LVL_MACH) && !m_en;
      h_fail = virt_on && !h_en;
      s_fail = super_on && (lvl == LVL_USER) && !s_en;

      allow    = valid && base_ok && (!stateen_on || (!m_fail && !h_fail && !s_fail));
      trap_ill = gated && (m_fail || (!h_fail && s_fail && !virt_on));
      trap_vrt = gated && !m_fail && (h_fail || (s_fail && virt_on));
   end
endmodule

// File: rtl/jtg_vec_reg.sv
`timescale 1ns/1ps
module jtg_vec_reg #(
   parameter int unsigned W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (we) q <= wdata;
   end

   assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> $stable(q));
   assert_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> (q == $past(wdata)));
endmodule

// File: rtl/jtab_csr_gate.sv
`timescale 1ns/1ps
module jtab_csr_gate
   import jtg_pkg::*;
#(
   parameter int unsigned XLEN       = DEF_XLEN,
   parameter int unsigned SE_W       = DEF_SE_W,
   parameter int unsigned JT_BIT     = DEF_JT_BIT,
   parameter bit          TJ_PRESENT = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            acc_valid,
   input  logic            acc_write,
   input  logic [XLEN-1:0] acc_wdata,
   input  logic            base_ok,
   input  logic            stateen_on,
   input  logic            super_on,
   input  logic            virt_on,
   input  logic [1:0]      prv,
   input  logic [SE_W-1:0] m_se,
   input  logic [SE_W-1:0] h_se,
   input  logic [SE_W-1:0] s_se,
   output logic            allow,
   output logic            trap_illegal,
   output logic            trap_virtual,
   output logic [XLEN-1:0] rd_data
);
   localparam int unsigned N_GATES = 3;

   if (XLEN != 32 && XLEN != 64) begin : g_bad_xlen
      $error("jtab_csr_gate: XLEN must be 32 or 64");
   end
   if (JT_BIT >= SE_W) begin : g_bad_bit
      $error("jtab_csr_gate: JT_BIT must lie inside SE_W");
   end

   lvl_e lvl;
   assign lvl = lvl_e'(prv);

   // one tap per state-enable register: 0 machine, 1 hypervisor, 2 supervisor
   logic [SE_W-1:0]    se_in [N_GATES];
   logic [N_GATES-1:0] gate_en;
   assign se_in[0] = m_se;
   assign se_in[1] = h_se;
   assign se_in[2] = s_se;

   for (genvar g = 0; g < N_GATES; g++) begin : g_tap
      jtg_enable_tap #(
         .SE_W    (SE_W),
         .BIT_POS (JT_BIT),
         .PRESENT (TJ_PRESENT)
      ) u_tap (
         .se (se_in[g]),
         .en (gate_en[g])
      );
   end

   jtg_gate_eval u_eval (
      .valid      (acc_valid),
      .base_ok    (base_ok),
      .stateen_on (stateen_on),
      .super_on   (super_on),
      .virt_on    (virt_on),
      .lvl        (lvl),
      .m_en       (gate_en[0]),
      .h_en       (gate_en[1]),
      .s_en       (gate_en[2]),
      .allow      (allow),
      .trap_ill   (trap_illegal),
      .trap_vrt   (trap_virtual)
   );

   logic wr_fire;
   assign wr_fire = acc_valid && acc_write && allow;

   jtg_vec_reg #(.W(XLEN)) u_reg (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (wr_fire),
      .wdata (acc_wdata),
      .q     (rd_data)
   );

   assert_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({allow, trap_illegal, trap_virtual}));
   assert_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_valid |-> !(allow || trap_illegal || trap_virtual));
   assert_base_fail_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && !base_ok) |=> $stable(rd_data));
   assert_base_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && !base_ok) |-> !(allow || trap_illegal || trap_virtual));
   assert_ungated_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && base_ok && !stateen_on) |-> allow);
   assert_mgate_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && base_ok && stateen_on && prv != 2'd3 && !gate_en[0]) |-> trap_illegal);
   assert_hgate_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && base_ok && stateen_on && (prv == 2'd3 || gate_en[0])
       && virt_on && !gate_en[1]) |-> trap_virtual);
   assert_sgate_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && base_ok && stateen_on && (prv == 2'd3 || gate_en[0])
       && (!virt_on || gate_en[1]) && super_on && prv == 2'd0 && !gate_en[2])
       |-> (virt_on ? trap_virtual : trap_illegal));
endmodule

// File: tb/jtab_csr_gate_test.sv
`timescale 1ns/1ps
module jtab_csr_gate_test;
   localparam int XLEN = 32;
   localparam int SE_W = 64;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            acc_valid = 1'b0, acc_write = 1'b0;
   logic [XLEN-1:0] acc_wdata = '0;
   logic            base_ok = 1'b0, stateen_on = 1'b0, super_on = 1'b0, virt_on = 1'b0;
   logic [1:0]      prv = 2'd0;
   logic [SE_W-1:0] m_se = '0, h_se = '0, s_se = '0;

   logic            allow_a, ill_a, vt_a;
   logic [XLEN-1:0] rd_a;
   logic            allow_b, ill_b, vt_b;
   logic [XLEN-1:0] rd_b;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   jtab_csr_gate #(.XLEN(XLEN), .SE_W(SE_W), .JT_BIT(2), .TJ_PRESENT(1'b1)) uut (
      .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
      .acc_wdata(acc_wdata), .base_ok(base_ok), .stateen_on(stateen_on),
      .super_on(super_on), .virt_on(virt_on), .prv(prv), .m_se(m_se),
      .h_se(h_se), .s_se(s_se), .allow(allow_a), .trap_illegal(ill_a),
      .trap_virtual(vt_a), .rd_data(rd_a));

   jtab_csr_gate #(.XLEN(XLEN), .SE_W(SE_W), .JT_BIT(2), .TJ_PRESENT(1'b0)) uut_nojt (
      .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
      .acc_wdata(acc_wdata), .base_ok(base_ok), .stateen_on(stateen_on),
      .super_on(super_on), .virt_on(virt_on), .prv(prv), .m_se(m_se),
      .h_se(h_se), .s_se(s_se), .allow(allow_b), .trap_illegal(ill_b),
      .trap_virtual(vt_b), .rd_data(rd_b));

   // returns {allow, illegal, virtual}
   function automatic logic [2:0] model(input logic vld, input logic [1:0] p,
         input logic v, input logic me, input logic he, input logic sen,
         input logic st, input logic sup, input logic bok);
      if (!vld || !bok) return 3'b000;
      if (!st) return 3'b100;
      if (p != 2'd3 && !me) return 3'b010;
      if (v && !he) return 3'b001;
      if (sup && p == 2'd0 && !sen) return v ? 3'b001 : 3'b010;
      return 3'b100;
   endfunction

   function automatic string tag_of(input logic [1:0] p, input logic v,
         input logic me, input logic he, input logic sen, input logic st,
         input logic sup, input logic bok);
      if (!bok) return "R1";
      if (!st) return "R2";
      if (p != 2'd3 && !me) return "R3";
      if (v && !he) return "R4/R6";
      if (sup && p == 2'd0 && !sen) return "R5/R6";
      return "R6/R7";
   endfunction

   task automatic chk(input string tag, input logic [XLEN-1:0] act,
                      input logic [XLEN-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         bad++;
         total++;
         $display("FAIL watchdog actual=timeout expected=done");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [XLEN-1:0] sh_a, sh_b;
      logic [2:0] ea, eb;
      repeat (3) @(negedge clk);
      // R8: reset value
      chk("R8 reset a", rd_a, '0);
      chk("R8 reset b", rd_b, '0);
      chk("R7 idle in reset", {29'd0, allow_a, ill_a, vt_a}, '0);
      rst_n = 1'b1;
      sh_a = '0;
      sh_b = '0;

      for (int i = 0; i < 512; i++) begin
         logic [SE_W-1:0] noise;
         @(negedge clk);
         chk("R9 stored a", rd_a, sh_a);
         chk("R10 stored b", rd_b, sh_b);
         noise = i[0] ? ~64'd0 : 64'd0;
         prv        = i[1:0];
         virt_on    = i[2];
         m_se       = noise; m_se[2] = i[3];
         h_se       = ~noise; h_se[2] = i[4];
         s_se       = noise; s_se[2] = i[5];
         stateen_on = i[6];
         super_on   = i[7];
         base_ok    = i[8];
         acc_valid  = 1'b1;
         acc_write  = 1'b1;
         acc_wdata  = 32'h9E37_79B9 * (i + 1);
         #2;
         ea = model(1'b1, prv, virt_on, i[3], i[4], i[5], i[6], i[7], i[8]);
         eb = model(1'b1, prv, virt_on, 1'b0, 1'b0, 1'b0, i[6], i[7], i[8]);
         chk({tag_of(prv, virt_on, i[3], i[4], i[5], i[6], i[7], i[8]), " verdict a"},
             {29'd0, allow_a, ill_a, vt_a}, {29'd0, ea});
         chk("R10 verdict b", {29'd0, allow_b, ill_b, vt_b}, {29'd0, eb});
         if (ea[2]) sh_a = acc_wdata;
         if (eb[2]) sh_b = acc_wdata;
      end

      // R7/R9: invalid access does nothing even with a write pending
      @(negedge clk);
      chk("R9 stored a", rd_a, sh_a);
      acc_valid  = 1'b0;
      acc_wdata  = 32'h1234_5678;
      base_ok    = 1'b1;
      stateen_on = 1'b0;
      #2;
      chk("R7 idle outputs", {29'd0, allow_a, ill_a, vt_a}, '0);
      @(negedge clk);
      chk("R9 no write when idle", rd_a, sh_a);

      // R9: allowed read leaves value, allowed write loads it
      acc_valid = 1'b1;
      acc_write = 1'b0;
      @(negedge clk);
      chk("R9 read no write", rd_a, sh_a);
      acc_write = 1'b1;
      acc_wdata = 32'hCAFE_F00C;
      @(negedge clk);
      chk("R9 write loads", rd_a, 32'hCAFE_F00C);
      chk("R10 ungated write b", rd_b, 32'hCAFE_F00C);

      // R8: reset again clears the register
      acc_valid = 1'b0;
      rst_n = 1'b0;
      #2;
      chk("R8 re-reset a", rd_a, '0);
      chk("R8 re-reset b", rd_b, '0);

      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule